// File: doc/BRIEF.md
# SMBus Host Controller Command Front-End

This block is the software-facing half of an SMBus host controller. It holds the byte-addressed register bank (protocol, status, slave address, command code, a 32-byte data buffer, byte count and alarm storage). It decides whether the transaction software asked for can be run, and it sequences that transaction with an external bit-level bus engine. Software fills in the address, command, data and count, then writes a nonzero protocol code to start. Completion shows in two ways. The protocol register reads zero again, and a done flag with a 5-bit result code appears in the status register.

A start is checked before anything leaves the block. An undefined protocol code completes at once with the "unsupported protocol" code. A block write whose byte count lies outside 1..32 does the same. Neither sends a request to the engine. A valid start raises a request that carries a snapshot of the registers and is held until the engine acknowledges with a result code and any read data. For successful reads, the returned bytes land in the data buffer. For block reads, the returned length also lands in the byte-count register. Every completion raises a one-cycle interrupt pulse.

Top module: `smbh_top`

## Requirements
- R1: After reset, every register reads 0x00, `engReq` is low and `irqPulse` is low.
- R2: Register offsets are: protocol 0x00, status 0x01, slave address 0x02, command 0x03, data bytes 0x04..0x23 (byte i at 0x04+i), byte count 0x24, alarm address 0x25 and alarm data 0x26..0x27. While idle, the address, command, data, count and alarm registers read back the last value written.
- R3: While idle, a write to 0x00 whose bits 6:0 lie in 0x02..0x0D starts a transaction. On the next cycle `engReq` is high, the protocol register reads back the written byte including bit 7 (the PEC request), and the request fields equal the register contents.
- R4: `engReq` and all request fields stay constant from the start until the cycle in which `engAck` is high.
- R5: When `engAck` is seen during a transaction, then on the next cycle the protocol register reads 0x00, the status register reads {done=1, bit6=0, bit5=0, code=`engResult`}, `engReq` is low and `irqPulse` is high for exactly that one cycle.
- R6: On a result of 0x00, read-type protocols copy `engRxData` into the data buffer (byte i to data[i], so a word has its low byte in data[0] and its high byte in data[1]). Read-type protocols are those with bit 0 set other than quick read 0x03, plus process call 0x0C. Block read 0x0B and block process call 0x0D also load `engRxCount` into the byte count.
- R7: On a nonzero result, the data buffer and the byte count are left unchanged.
- R8: A start of block write 0x0A or block process call 0x0D with a byte count of 0 or above 32 completes on the next cycle with status 0x99 (done plus code 0x19). No request is raised, the protocol register stays 0x00 and a one-cycle interrupt pulse is raised. A count of exactly 32 starts normally.
- R9: A nonzero protocol write whose bits 6:0 are outside 0x02..0x0D completes on the next cycle with status 0x99 and an interrupt pulse, and no request is raised.
- R10: During a transaction, a protocol write is ignored except that the status code becomes 0x1A (done unchanged). Writes to the address, command, data and count registers are ignored.
- R11: Writing the status register with bit 7 set clears the done flag. Writing it with bit 7 clear leaves status unchanged.
- R12: Status bit 6 (alarm) reads 0, and bits 4:0 hold the most recent code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 6 | Register byte offset for reads and writes |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for `regAddr` (combinational) |
| irqPulse | output | 1 | One-cycle completion pulse |
| engReq | output | 1 | Transaction request to the bus engine |
| engProto | output | 8 | Protocol code of the request |
| engSlave | output | 8 | Slave address byte of the request |
| engCmd | output | 8 | Command code of the request |
| engCount | output | 8 | Byte count of the request |
| engTxData | output | 256 | Data buffer, byte i at bits 8i+7:8i |
| engAck | input | 1 | Engine completion acknowledge |
| engResult | input | 5 | Result code returned with the acknowledge |
| engRxCount | input | 8 | Length returned by a block read |
| engRxData | input | 256 | Read data, byte i at bits 8i+7:8i |

## Verification
A wrong busy state shows at the ports within one cycle. Either `engReq` drops or never rises, or the protocol register stays nonzero after the acknowledge. A wrong decode of the protocol byte shows on the cycle after the start, as a request where status 0x99 was due or the reverse. A wrong capture decision shows only when the data and count registers are read after completion, so each read protocol is followed by a read-back of the buffer. Stale done or code state shows on the next status read, which the bench takes after every completion and every clear.

// File: rtl/smbh_pkg.sv
package smbh_pkg;

  localparam logic [4:0] CODE_OK      = 5'h00;
  localparam logic [4:0] CODE_UNSUPP  = 5'h19;
  localparam logic [4:0] CODE_BUSY    = 5'h1A;

  localparam int OFF_PROTO   = 'h00;
  localparam int OFF_STATUS  = 'h01;
  localparam int OFF_SLAVE   = 'h02;
  localparam int OFF_CMD     = 'h03;
  localparam int OFF_DATA0   = 'h04;

  typedef struct packed {
    logic       loadProto;
    logic       clearProto;
    logic       setDone;
    logic       clrDone;
    logic       loadCode;
    logic [4:0] codeVal;
    logic       loadRx;
    logic       loadRxCnt;
    logic       cfgWrEn;
  } ctrlStrobe_t;

  function automatic logic isValidCode(input logic [7:0] p);
    return (p[6:0] >= 7'h02) && (p[6:0] <= 7'h0D);
  endfunction

  function automatic logic isBlockWrite(input logic [7:0] p);
    return (p[6:0] == 7'h0A) || (p[6:0] == 7'h0D);
  endfunction

  function automatic logic isReadType(input logic [7:0] p);
    return (p[0] && (p[6:0] != 7'h03)) || (p[6:0] == 7'h0C);
  endfunction

  function automatic logic isBlockRead(input logic [7:0] p);
    return (p[6:0] == 7'h0B) || (p[6:0] == 7'h0D);
  endfunction

endpackage

// File: rtl/smbh_ctrl.sv
module smbh_ctrl
  import smbh_pkg::*;
#(
  parameter int DATA_BYTES = 32,
  parameter int ADDR_W     = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  input  logic [7:0]        curProto,
  input  logic [7:0]        byteCount,
  input  logic              engAck,
  input  logic [4:0]        engResult,
  output logic              busy,
  output logic              irqPulse,
  output ctrlStrobe_t       strb
);

  logic busyQ, busyD;
  logic irqQ, irqD;
  logic protoWr, statusWr, badCount;

  assign protoWr  = regWrEn && (regAddr == ADDR_W'(OFF_PROTO)) && (regWrData != 8'h00);
  assign statusWr = regWrEn && (regAddr == ADDR_W'(OFF_STATUS));
  assign badCount = (byteCount == 8'h00) || (byteCount > 8'(DATA_BYTES));

  always_comb begin
    strb    = '0;
    busyD   = busyQ;
    irqD    = 1'b0;

    strb.cfgWrEn = regWrEn && !busyQ &&
                   (regAddr != ADDR_W'(OFF_PROTO)) &&
                   (regAddr != ADDR_W'(OFF_STATUS));
    strb.clrDone = statusWr && regWrData[7];

    if (!busyQ) begin
      if (protoWr) begin
        if (!isValidCode(regWrData) || (isBlockWrite(regWrData) && badCount)) begin
          strb.setDone  = 1'b1;
          strb.loadCode = 1'b1;
          strb.codeVal  = CODE_UNSUPP;
          irqD          = 1'b1;
        end else begin
          strb.loadProto = 1'b1;
          busyD          = 1'b1;
        end
      end
    end else begin
      if (protoWr) begin
        strb.loadCode = 1'b1;
        strb.codeVal  = CODE_BUSY;
      end
      if (engAck) begin
        strb.clearProto = 1'b1;
        strb.setDone    = 1'b1;
        strb.loadCode   = 1'b1;
        strb.codeVal    = engResult;
        strb.loadRx     = (engResult == CODE_OK) && isReadType(curProto);
        strb.loadRxCnt  = (engResult == CODE_OK) && isBlockRead(curProto);
        busyD           = 1'b0;
        irqD            = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      irqQ  <= 1'b0;
    end else begin
      busyQ <= busyD;
      irqQ  <= irqD;
    end
  end

  assign busy     = busyQ;
  assign irqPulse = irqQ;

endmodule

// File: rtl/smbh_dpath.sv
module smbh_dpath
  import smbh_pkg::*;
#(
  parameter int DATA_BYTES = 32,
  parameter int ADDR_W     = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       regAddr,
  input  logic [7:0]              regWrData,
  input  ctrlStrobe_t             strb,
  input  logic [7:0]              engRxCount,
  input  logic [8*DATA_BYTES-1:0] engRxData,
  output logic [7:0]              regRdData,
  output logic [7:0]              protoOut,
  output logic [7:0]              slaveOut,
  output logic [7:0]              cmdOut,
  output logic [7:0]              countOut,
  output logic [8*DATA_BYTES-1:0] txData
);

  localparam int IDX_W      = $clog2(DATA_BYTES);
  localparam int OFF_COUNT  = OFF_DATA0 + DATA_BYTES;
  localparam int OFF_ALMA   = OFF_COUNT + 1;
  localparam int OFF_ALMD0  = OFF_COUNT + 2;
  localparam int OFF_ALMD1  = OFF_COUNT + 3;

  logic [7:0] protoQ, slaveQ, cmdQ, countQ, almAddrQ;
  logic [7:0] almDataQ [2];
  logic [7:0] dataQ [DATA_BYTES];
  logic       doneQ;
  logic [4:0] codeQ;
  logic [IDX_W-1:0] dIdx;
  logic       inData;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
    return a == ADDR_W'(off);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      protoQ   <= '0;
      doneQ    <= 1'b0;
      codeQ    <= '0;
      slaveQ   <= '0;
      cmdQ     <= '0;
      countQ   <= '0;
      almAddrQ <= '0;
      almDataQ[0] <= '0;
      almDataQ[1] <= '0;
    end else begin
      if (strb.loadProto)       protoQ <= regWrData;
      else if (strb.clearProto) protoQ <= 8'h00;

      if (strb.setDone)         doneQ <= 1'b1;
      else if (strb.clrDone)    doneQ <= 1'b0;

      if (strb.loadCode)        codeQ <= strb.codeVal;

      if (strb.cfgWrEn && hit(regAddr, OFF_SLAVE)) slaveQ   <= regWrData;
      if (strb.cfgWrEn && hit(regAddr, OFF_CMD))   cmdQ     <= regWrData;
      if (strb.cfgWrEn && hit(regAddr, OFF_ALMA))  almAddrQ <= regWrData;
      if (strb.cfgWrEn && hit(regAddr, OFF_ALMD0)) almDataQ[0] <= regWrData;
      if (strb.cfgWrEn && hit(regAddr, OFF_ALMD1)) almDataQ[1] <= regWrData;

      if (strb.loadRxCnt)                                countQ <= engRxCount;
      else if (strb.cfgWrEn && hit(regAddr, OFF_COUNT))  countQ <= regWrData;
    end
  end

  for (genvar i = 0; i < DATA_BYTES; i++) begin : gByte
    always_ff @(posedge clk) begin
      if (!rstN)
        dataQ[i] <= '0;
      else if (strb.loadRx)
        dataQ[i] <= engRxData[8*i +: 8];
      else if (strb.cfgWrEn && hit(regAddr, OFF_DATA0 + i))
        dataQ[i] <= regWrData;
    end
    assign txData[8*i +: 8] = dataQ[i];
  end

  assign dIdx   = IDX_W'(regAddr - ADDR_W'(OFF_DATA0));
  assign inData = (regAddr >= ADDR_W'(OFF_DATA0)) && (regAddr < ADDR_W'(OFF_COUNT));

  always_comb begin
    regRdData = 8'h00;
    if (inData)                       regRdData = dataQ[dIdx];
    else if (hit(regAddr, OFF_PROTO))  regRdData = protoQ;
    else if (hit(regAddr, OFF_STATUS)) regRdData = {doneQ, 1'b0, 1'b0, codeQ};
    else if (hit(regAddr, OFF_SLAVE))  regRdData = slaveQ;
    else if (hit(regAddr, OFF_CMD))    regRdData = cmdQ;
    else if (hit(regAddr, OFF_COUNT))  regRdData = countQ;
    else if (hit(regAddr, OFF_ALMA))   regRdData = almAddrQ;
    else if (hit(regAddr, OFF_ALMD0))  regRdData = almDataQ[0];
    else if (hit(regAddr, OFF_ALMD1))  regRdData = almDataQ[1];
  end

  assign protoOut = protoQ;
  assign slaveOut = slaveQ;
  assign cmdOut   = cmdQ;
  assign countOut = countQ;

endmodule

// File: rtl/smbh_top.sv
module smbh_top
  import smbh_pkg::*;
#(
  parameter int DATA_BYTES = 32,
  parameter int ADDR_W     = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       regAddr,
  input  logic                    regWrEn,
  input  logic [7:0]              regWrData,
  output logic [7:0]              regRdData,
  output logic                    irqPulse,
  output logic                    engReq,
  output logic [7:0]              engProto,
  output logic [7:0]              engSlave,
  output logic [7:0]              engCmd,
  output logic [7:0]              engCount,
  output logic [8*DATA_BYTES-1:0] engTxData,
  input  logic                    engAck,
  input  logic [4:0]              engResult,
  input  logic [7:0]              engRxCount,
  input  logic [8*DATA_BYTES-1:0] engRxData
);

  ctrlStrobe_t strb;
  logic [7:0]  protoCur;
  logic [7:0]  countCur;

  smbh_ctrl #(.DATA_BYTES(DATA_BYTES), .ADDR_W(ADDR_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .curProto  (protoCur),
    .byteCount (countCur),
    .engAck    (engAck),
    .engResult (engResult),
    .busy      (engReq),
    .irqPulse  (irqPulse),
    .strb      (strb)
  );

  smbh_dpath #(.DATA_BYTES(DATA_BYTES), .ADDR_W(ADDR_W)) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .strb       (strb),
    .engRxCount (engRxCount),
    .engRxData  (engRxData),
    .regRdData  (regRdData),
    .protoOut   (protoCur),
    .slaveOut   (engSlave),
    .cmdOut     (engCmd),
    .countOut   (countCur),
    .txData     (engTxData)
  );

  assign engProto = protoCur;
  assign engCount = countCur;

endmodule

// File: rtl/smbh_chk.sv
module smbh_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [7:0]        regWrData,
  input logic              irqPulse,
  input logic              engReq,
  input logic              engAck,
  input logic [7:0]        engProto,
  input logic [7:0]        engSlave,
  input logic [7:0]        engCmd,
  input logic [7:0]        engCount
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    engReq && !engAck |=> engReq); // R4

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    engReq && !engAck |=> $stable(engProto) && $stable(engSlave) && $stable(engCmd) && $stable(engCount)); // R4

  AST_ACK_COMPLETES: assert property (@(posedge clk) disable iff (!rstN)
    engReq && engAck |=> irqPulse && !engReq); // R5

  AST_BAD_CODE_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !engReq && regWrEn && regAddr == '0 && regWrData != 8'h00 && regWrData[6:0] == 7'h00 |=> !engReq && irqPulse); // R9

  AST_START_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !engReq && regWrEn && regAddr == '0 && regWrData[6:0] == 7'h06 |=> engReq && engProto == $past(regWrData)); // R3

  AST_IDLE_PROTO_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !engReq |-> engProto == 8'h00); // R5

endmodule

bind smbh_top smbh_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .irqPulse  (irqPulse),
  .engReq    (engReq),
  .engAck    (engAck),
  .engProto  (engProto),
  .engSlave  (engSlave),
  .engCmd    (engCmd),
  .engCount  (engCount)
);

// File: tb/smbh_top_tb_top.sv
`timescale 1ns/1ps
module smbh_top_tb_top;

  localparam int NB = 32;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [5:0]     regAddr = '0;
  logic           regWrEn = 1'b0;
  logic [7:0]     regWrData = '0;
  logic [7:0]     regRdData;
  logic           irqPulse;
  logic           engReq;
  logic [7:0]     engProto, engSlave, engCmd, engCount;
  logic [8*NB-1:0] engTxData;
  logic           engAck = 1'b0;
  logic [4:0]     engResult = '0;
  logic [7:0]     engRxCount = '0;
  logic [8*NB-1:0] engRxData = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  smbh_top dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .irqPulse(irqPulse),
    .engReq(engReq), .engProto(engProto), .engSlave(engSlave),
    .engCmd(engCmd), .engCount(engCount), .engTxData(engTxData),
    .engAck(engAck), .engResult(engResult), .engRxCount(engRxCount),
    .engRxData(engRxData)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [5:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic expectReg(input string req, input logic [5:0] a, input logic [7:0] exp);
    logic [7:0] v;
    readReg(a, v);
    chk(req, {24'h0, v}, {24'h0, exp});
  endtask

  // Engine acknowledges; on return, completion cycle is visible.
  task automatic engineAck(input logic [4:0] res, input logic [7:0] rxCnt, input logic [7:0] seed);
    @(negedge clk);
    for (int i = 0; i < NB; i++) engRxData[8*i +: 8] = seed + 8'(i);
    engRxCount = rxCnt; engResult = res; engAck = 1'b1;
    @(negedge clk);
    engAck = 1'b0;
  endtask

  task automatic clearDone();
    writeReg(6'h01, 8'h80);
  endtask

  task automatic t_reset();
    chk("R1 engReq", {31'h0, engReq}, 0);
    chk("R1 irq", {31'h0, irqPulse}, 0);
    expectReg("R1 proto", 6'h00, 8'h00);
    expectReg("R1 status", 6'h01, 8'h00);
    expectReg("R1 slave", 6'h02, 8'h00);
    expectReg("R1 data0", 6'h04, 8'h00);
    expectReg("R1 count", 6'h24, 8'h00);
  endtask

  task automatic t_regmap();
    writeReg(6'h02, 8'hA4);
    writeReg(6'h03, 8'h33);
    writeReg(6'h04, 8'h11);
    writeReg(6'h23, 8'h99);
    writeReg(6'h24, 8'h03);
    writeReg(6'h25, 8'h5C);
    writeReg(6'h27, 8'hE1);
    expectReg("R2 slave", 6'h02, 8'hA4);
    expectReg("R2 cmd", 6'h03, 8'h33);
    expectReg("R2 data0", 6'h04, 8'h11);
    expectReg("R2 data31", 6'h23, 8'h99);
    expectReg("R2 count", 6'h24, 8'h03);
    expectReg("R2 alarm addr", 6'h25, 8'h5C);
    expectReg("R2 alarm data1", 6'h27, 8'hE1);
    expectReg("R2 alarm data0", 6'h26, 8'h00);
  endtask

  task automatic t_writeByteData();
    writeReg(6'h00, 8'h06);
    chk("R3 req", {31'h0, engReq}, 1);
    chk("R3 proto field", {24'h0, engProto}, 8'h06);
    chk("R3 slave field", {24'h0, engSlave}, 8'hA4);
    chk("R3 cmd field", {24'h0, engCmd}, 8'h33);
    chk("R3 data field", {24'h0, engTxData[7:0]}, 8'h11);
    expectReg("R3 proto readback", 6'h00, 8'h06);
    repeat (3) @(negedge clk);
    chk("R4 req held", {31'h0, engReq}, 1);
    writeReg(6'h02, 8'h77);
    chk("R10 slave write ignored", {24'h0, engSlave}, 8'hA4);
    writeReg(6'h00, 8'h08);
    expectReg("R10 busy code", 6'h01, 8'h1A);
    chk("R10 proto unchanged", {24'h0, engProto}, 8'h06);
    chk("R4 slave stable", {24'h0, engSlave}, 8'hA4);
    engineAck(5'h00, 8'h00, 8'h00);
    chk("R5 irq", {31'h0, irqPulse}, 1);
    chk("R5 req low", {31'h0, engReq}, 0);
    expectReg("R5 proto zero", 6'h00, 8'h00);
    expectReg("R5 R12 status", 6'h01, 8'h80);
    expectReg("R7 write keeps data", 6'h04, 8'h11);
    @(negedge clk);
    chk("R5 irq one cycle", {31'h0, irqPulse}, 0);
  endtask

  task automatic t_clearDone();
    writeReg(6'h01, 8'h7F);
    expectReg("R11 bit7 clear no effect", 6'h01, 8'h80);
    clearDone();
    expectReg("R11 done cleared", 6'h01, 8'h00);
  endtask

  task automatic t_readWord();
    writeReg(6'h00, 8'h09);
    engineAck(5'h00, 8'h00, 8'h34);
    expectReg("R6 word low byte", 6'h04, 8'h34);
    expectReg("R6 word high byte", 6'h05, 8'h35);
    expectReg("R6 word keeps count", 6'h24, 8'h03);
    clearDone();
  endtask

  task automatic t_blockRead();
    writeReg(6'h24, 8'h05);
    writeReg(6'h00, 8'h0B);
    chk("R3 block read count field", {24'h0, engCount}, 8'h05);
    engineAck(5'h00, 8'h07, 8'hC0);
    expectReg("R6 block read count", 6'h24, 8'h07);
    expectReg("R6 block read data6", 6'h0A, 8'hC6);
    expectReg("R12 status ok", 6'h01, 8'h80);
    clearDone();
  endtask

  task automatic t_failedRead();
    writeReg(6'h00, 8'h05);
    engineAck(5'h10, 8'h01, 8'h50);
    expectReg("R7 R12 nack status", 6'h01, 8'h90);
    expectReg("R7 data unchanged", 6'h04, 8'hC0);
    expectReg("R7 count unchanged", 6'h24, 8'h07);
    clearDone();
  endtask

  task automatic t_badBlockWrite();
    writeReg(6'h24, 8'h00);
    writeReg(6'h00, 8'h0A);
    chk("R8 count0 no req", {31'h0, engReq}, 0);
    chk("R8 count0 irq", {31'h0, irqPulse}, 1);
    expectReg("R8 count0 status", 6'h01, 8'h99);
    expectReg("R8 count0 proto", 6'h00, 8'h00);
    clearDone();
    writeReg(6'h24, 8'd33);
    writeReg(6'h00, 8'h0D);
    chk("R8 count33 no req", {31'h0, engReq}, 0);
    expectReg("R8 count33 status", 6'h01, 8'h99);
    clearDone();
    writeReg(6'h24, 8'd32);
    writeReg(6'h00, 8'h0A);
    chk("R8 count32 starts", {31'h0, engReq}, 1);
    engineAck(5'h00, 8'h00, 8'h00);
    expectReg("R8 count32 status", 6'h01, 8'h80);
    clearDone();
  endtask

  task automatic t_undefined();
    writeReg(6'h00, 8'h0E);
    chk("R9 0x0E no req", {31'h0, engReq}, 0);
    chk("R9 0x0E irq", {31'h0, irqPulse}, 1);
    expectReg("R9 0x0E status", 6'h01, 8'h99);
    clearDone();
    writeReg(6'h00, 8'h80);
    chk("R9 pec only no req", {31'h0, engReq}, 0);
    expectReg("R9 pec only status", 6'h01, 8'h99);
    clearDone();
  endtask

  task automatic t_pecQuick();
    writeReg(6'h00, 8'h83);
    chk("R3 pec quick req", {31'h0, engReq}, 1);
    expectReg("R3 pec readback", 6'h00, 8'h83);
    engineAck(5'h18, 8'h00, 8'h00);
    expectReg("R5 timeout status", 6'h01, 8'h98);
    clearDone();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_writeByteData();
    t_clearDone();
    t_readWord();
    t_blockRead();
    t_failedRead();
    t_badBlockWrite();
    t_undefined();
    t_pecQuick();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule